// File: doc/BRIEF.md
# Up-Counting Period Timer with Compare and Wrap Flags

This block is a free-running period timer. A counter advances by one on each cycle where the `tick` enable is high. It counts up until it equals a programmable period value, and on the next tick it returns to zero. One full period therefore lasts period + 1 ticks. Two sticky event flags mark the cycle. The compare flag is raised on the tick where the counter arrives at the period value. The wrap flag is raised one tick later, when the counter drops back to zero. Each flag has its own enable, and the single interrupt line is high while any enabled flag is set.

Software programs the block through a small write port that has two targets. The first is the period register. The second is a control word that holds the run mode and the two enables, together with write-one strobes that clear the counter or either flag. If the period register holds zero, the counter halts where it is, just as it does in the stop mode. Writing a nonzero period after such a halt starts the count again from zero.

Top module: `uptimer`

## Requirements
- R1: After synchronous reset (active-low `rst_n`), `count`, both flags, `irq`, the period register and both enables are zero, and the mode is stop.
- R2: When the mode is up (control bits [1:0] = 01), the period is nonzero and `tick` is high, a counter below the period increments by one on the next cycle.
- R3: When `count` equals the period on a ticked cycle in up mode, the counter becomes zero on the next cycle, so one period lasts period + 1 ticks.
- R4: The compare flag `cmp_flag` is set on the same edge where `count` becomes equal to the period.
- R5: The wrap flag `ovf_flag` is set on the edge where `count` goes from the period back to zero, one tick after the compare flag.
- R6: On cycles where `tick` is low, the counter holds its value.
- R7: While the period register is zero, the counter holds its value and neither flag is set, whatever the state of `tick`.
- R8: A write of a nonzero period (`wr_sel` = 0) while the period register holds zero forces the counter to zero. Counting then resumes upward from zero.
- R9: Mode codes 00, 10 and 11 are stop codes. In those modes the counter holds its value.
- R10: Both flags are sticky. A flag is cleared only by a control write (`wr_sel` = 1) with bit 5 (compare) or bit 6 (wrap) set. If a clear and a set event reach the same flag in the same cycle, the set wins.
- R11: `irq` is high exactly when (`cmp_flag` and enable bit 3) or (`ovf_flag` and enable bit 4). The enables are stored from control writes.
- R12: A control write with bit 2 set forces `count` to zero on the next cycle and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 control |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The hardest case to reach is a compare event and a software clear of the same flag landing on the same edge. To produce it, the stimulus walks the counter to one below the period and then raises `tick` in the very cycle that carries the flag-clear control write. The halt-and-resume path is also hard to reach. It needs a counter stopped part-way through a period, several ignored ticks, and then a nonzero period write, after which the counter must restart at zero rather than continue from its old value. The main count and flag sequence is swept over every period from 1 to 9, with tick spacings of one to three cycles.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

    localparam logic [1:0] MODE_STOP = 2'b00;
    localparam logic [1:0] MODE_UP   = 2'b01;

    // control word bit positions
    localparam int CTL_MODE_LSB = 0;
    localparam int CTL_CLR_CNT  = 2;
    localparam int CTL_CMP_EN   = 3;
    localparam int CTL_OVF_EN   = 4;
    localparam int CTL_CMP_CLR  = 5;
    localparam int CTL_OVF_CLR  = 6;
    localparam int CTL_MIN_W    = 7;

    // flag indices
    localparam int FLAG_CMP = 0;
    localparam int FLAG_OVF = 1;
    localparam int NUM_FLAGS = 2;

    typedef struct packed {
        logic [1:0] mode;
        logic       cmp_en;
        logic       ovf_en;
    } ctrl_t;

endpackage

// File: rtl/uptimer_count.sv
module uptimer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             zero_now,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cmp_evt,
    output logic             ovf_evt
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_top;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign at_top  = (cnt_q == period);

    always_comb begin
        cnt_d   = cnt_q;
        cmp_evt = 1'b0;
        ovf_evt = 1'b0;
        if (zero_now) begin
            cnt_d = '0;
        end else if (tick && run) begin
            if (at_top) begin
                cnt_d   = '0;
                ovf_evt = 1'b1;
            end else begin
                cnt_d   = cnt_inc;
                cmp_evt = (cnt_inc == period);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/uptimer_flag.sv
module uptimer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);

    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;   // set outranks clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

endmodule

// File: rtl/uptimer.sv
module uptimer
    import uptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] period;
        ctrl_t            ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                 per_wr, ctl_wr;
    logic                 zero_now, run;
    logic                 cmp_evt, ovf_evt;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_en, flags;
    logic [CNT_W-1:0]     period_q;
    logic [1:0]           mode_q;

    assign per_wr = wr_en && !wr_sel;
    assign ctl_wr = wr_en && wr_sel;

    always_comb begin
        regs_d = regs_q;
        if (per_wr) regs_d.period = wr_data;
        if (ctl_wr) begin
            regs_d.ctrl.mode   = wr_data[CTL_MODE_LSB +: 2];
            regs_d.ctrl.cmp_en = wr_data[CTL_CMP_EN];
            regs_d.ctrl.ovf_en = wr_data[CTL_OVF_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.period      <= '0;
            regs_q.ctrl.mode   <= MODE_STOP;
            regs_q.ctrl.cmp_en <= 1'b0;
            regs_q.ctrl.ovf_en <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run      = (regs_q.ctrl.mode == MODE_UP) && (regs_q.period != '0);
    assign zero_now = (ctl_wr && wr_data[CTL_CLR_CNT])
                   || (per_wr && (regs_q.period == '0) && (wr_data != '0));

    uptimer_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .zero_now (zero_now),
        .period   (regs_q.period),
        .cnt_q    (count),
        .cmp_evt  (cmp_evt),
        .ovf_evt  (ovf_evt)
    );

    always_comb begin
        flag_set           = '0;
        flag_clr           = '0;
        flag_en            = '0;
        flag_set[FLAG_CMP] = cmp_evt;
        flag_set[FLAG_OVF] = ovf_evt;
        flag_clr[FLAG_CMP] = ctl_wr && wr_data[CTL_CMP_CLR];
        flag_clr[FLAG_OVF] = ctl_wr && wr_data[CTL_OVF_CLR];
        flag_en[FLAG_CMP]  = regs_q.ctrl.cmp_en;
        flag_en[FLAG_OVF]  = regs_q.ctrl.ovf_en;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        uptimer_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (flag_set[g]),
            .clr    (flag_clr[g]),
            .flag_q (flags[g])
        );
    end

    assign cmp_flag = flags[FLAG_CMP];
    assign ovf_flag = flags[FLAG_OVF];
    assign irq      = |(flags & flag_en);

    assign period_q = regs_q.period;
    assign mode_q   = regs_q.ctrl.mode;

endmodule

// File: rtl/uptimer_chk.sv
module uptimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic [1:0]       mode,
    input logic             cmp_flag,
    input logic             ovf_flag
);

    logic running;
    assign running = (mode == 2'b01) && (period != '0);

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && count != period && !wr_en)
        |=> count == CNT_W'($past(count) + 1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && count == period && !wr_en) |=> count == '0);

    p_cmp_at_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmp_flag) && !$past(wr_en)) |-> (count == period));

    p_ovf_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));

    p_zero_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && !wr_en) |=> ($stable(count) && !$rose(cmp_flag) && !$rose(ovf_flag)));

    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01 && !wr_en) |=> $stable(count));

    p_sticky_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !(wr_en && wr_sel && wr_data[5])) |=> cmp_flag);

    p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_sel && wr_data[6])) |=> ovf_flag);

    p_clr_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[2] && !wr_data[5] && !wr_data[6])
        |=> (count == '0 && cmp_flag == $past(cmp_flag) && ovf_flag == $past(ovf_flag)));

endmodule

bind uptimer uptimer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .count    (count),
    .period   (period_q),
    .mode     (mode_q),
    .cmp_flag (cmp_flag),
    .ovf_flag (ovf_flag)
);

// File: tb/test_uptimer.sv
module test_uptimer;

    localparam int W = 16;
    localparam logic [W-1:0] C_UP   = 16'h0001;
    localparam logic [W-1:0] C_CLR  = 16'h0004;
    localparam logic [W-1:0] C_CEN  = 16'h0008;
    localparam logic [W-1:0] C_OEN  = 16'h0010;
    localparam logic [W-1:0] C_CCLR = 16'h0020;
    localparam logic [W-1:0] C_OCLR = 16'h0040;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         cmp_flag, ovf_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uptimer #(.CNT_W(W)) i_uptimer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        idle(3);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 cmp", int'(cmp_flag), 0);
        chk("R1 ovf", int'(ovf_flag), 0);
        chk("R1 irq", int'(irq), 0);
        @(negedge clk); rst_n = 1'b1;
        // R1: stop mode after reset, zero period -> ticks ignored
        do_tick();
        chk("R1 idle after reset", int'(count), 0);

        // R2 R3 R4 R5 R6 sweep over periods and tick spacing
        for (int p = 1; p <= 9; p++) begin
            for (int gap = 0; gap <= 2; gap++) begin
                wr(1'b0, W'(p));
                wr(1'b1, C_UP | C_CLR | C_CEN | C_OEN | C_CCLR | C_OCLR);
                chk("R12 start zero", int'(count), 0);
                chk("R10 cleared cmp", int'(cmp_flag), 0);
                for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
                    do_tick();
                    chk("R2 R3 count", int'(count), k % (p + 1));
                    chk("R4 cmp", int'(cmp_flag), (k >= p) ? 1 : 0);
                    chk("R5 ovf", int'(ovf_flag), (k >= p + 1) ? 1 : 0);
                    chk("R11 irq both", int'(irq), (k >= p) ? 1 : 0);
                    held = int'(count);
                    idle(gap);
                    if (gap > 0) chk("R6 hold", int'(count), held);
                end
            end
        end

        // R10 set wins over same-cycle clear
        wr(1'b0, 16'd4);
        wr(1'b1, C_UP | C_CLR | C_CEN | C_OEN | C_CCLR | C_OCLR);
        do_tick(); do_tick(); do_tick();
        chk("R10 pre count", int'(count), 3);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b1;
        wr_data = C_UP | C_CEN | C_OEN | C_CCLR;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R10 set wins", int'(cmp_flag), 1);
        chk("R4 count at top", int'(count), 4);
        do_tick();
        chk("R5 wrap", int'(ovf_flag), 1);
        chk("R10 sticky cmp", int'(cmp_flag), 1);
        wr(1'b1, C_UP | C_CEN | C_OEN | C_CCLR);
        chk("R10 w1c cmp", int'(cmp_flag), 0);
        chk("R10 ovf kept", int'(ovf_flag), 1);

        // R11 enable masking
        wr(1'b1, C_UP | C_CLR | C_OEN | C_CCLR | C_OCLR);
        do_tick(); do_tick(); do_tick(); do_tick();
        chk("R11 cmp masked flag", int'(cmp_flag), 1);
        chk("R11 cmp masked irq", int'(irq), 0);
        do_tick();
        chk("R11 ovf irq", int'(irq), 1);
        wr(1'b1, C_UP | C_CEN);
        chk("R11 cmp only irq", int'(irq), 1);
        wr(1'b1, C_UP);
        chk("R11 no enables irq", int'(irq), 0);

        // R7 zero period halt, R8 restart
        wr(1'b0, 16'd8);
        wr(1'b1, C_UP | C_CLR | C_CCLR | C_OCLR);
        do_tick(); do_tick(); do_tick();
        chk("R7 pre count", int'(count), 3);
        wr(1'b0, 16'd0);
        for (int i = 0; i < 5; i++) do_tick();
        chk("R7 held count", int'(count), 3);
        chk("R7 no cmp", int'(cmp_flag), 0);
        chk("R7 no ovf", int'(ovf_flag), 0);
        wr(1'b0, 16'd5);
        chk("R8 restart zero", int'(count), 0);
        do_tick();
        chk("R8 counts up", int'(count), 1);

        // R9 stop codes
        wr(1'b1, 16'h0000);
        do_tick(); do_tick(); do_tick();
        chk("R9 mode 00", int'(count), 1);
        wr(1'b1, 16'h0003);
        do_tick(); do_tick();
        chk("R9 mode 11", int'(count), 1);
        wr(1'b1, 16'h0002);
        do_tick();
        chk("R9 mode 10", int'(count), 1);
        wr(1'b1, C_UP);
        do_tick();
        chk("R9 resume", int'(count), 2);

        // R12 clear counter keeps flags
        wr(1'b0, 16'd3);
        wr(1'b1, C_UP | C_CLR | C_CCLR | C_OCLR);
        for (int i = 0; i < 4; i++) do_tick();
        do_tick(); do_tick();
        chk("R12 pre count", int'(count), 2);
        wr(1'b1, C_UP | C_CLR);
        chk("R12 count zero", int'(count), 0);
        chk("R12 cmp kept", int'(cmp_flag), 1);
        chk("R12 ovf kept", int'(ovf_flag), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule